// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital half of an eight-input successive-approximation converter. It holds a control word written through a single write strobe. From that word it derives a conversion clock enable by dividing the bus clock. It steers an external analog multiplexer and drives a trial code to an external DAC. It builds each result one bit at a time from an external comparator, starting at the most significant bit.

The block runs in two ways. In software mode a start-now code launches one full-precision conversion on the lowest selected input, and the block then goes idle. In burst mode it converts the selected inputs over and over, from the lowest selected input upward, and wraps around at the top. A length code trades result precision against conversion time. Each finished result is presented with its channel number and a one-cycle done strobe. Results shorter than ten bits are left-aligned, and their unresolved low bits are zero.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, res_done, res_data, res_chan, mux_sel and dac_code are all zero. The stored control word is: mask 0x01, divider 0, burst off, length code 000, start code 000, converter off.
- R2: While the stored on bit is 0, no conversion runs and res_done stays low. Clearing it during a conversion abandons that conversion, and no done follows.
- R3: A conversion step happens once every (divider + 1) bus cycles. In burst mode, consecutive done strobes are therefore exactly N*(divider+1) bus cycles apart, where N is the conversion length in steps.
- R4: In software mode (burst 0, on 1), the start code 001 begins one conversion on the lowest selected channel, and the code is consumed when the conversion begins. With divider 0, res_done is high after the 12th rising edge counted from the edge that stored the code. No further conversion follows. Start codes 010 to 111 begin nothing.
- R5: A software-mode conversion always takes 11 steps and yields a full 10-bit result, whatever the length code.
- R6: A channel mask of 0x00 behaves exactly like 0x01, so only channel 0 is converted.
- R7: cmp_hi high means the analog input is at or above dac_code. Bits are tried from bit 9 downward. The result is the input value with its unresolved low bits cleared.
- R8: In burst mode, length code c (0 to 7) gives N = 11 - c steps and 10 - c result bits, left-aligned in res_data.
- R9: Burst scanning starts at the lowest set mask bit. It then moves to each higher set bit in turn and wraps from the highest back to the lowest.
- R10: With burst set, no conversion begins while the start code is not 000.
- R11: Clearing burst lets the conversion in progress deliver its result, and then the block stops. A write that lands on the very edge where a conversion finishes takes effect one edge later, so exactly one more conversion is delivered.
- R12: res_done is high for one bus cycle per result. res_data and res_chan hold until the next result, and mux_sel does not change while bits are being tried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Stores all cfg_* fields on this edge |
| cfg_chmask | input | NCH | Channel-select mask, bit i = channel i |
| cfg_div | input | DIVW | Clock divider; step rate = bus clock / (value + 1) |
| cfg_burst | input | 1 | 1 = continuous scanning |
| cfg_len | input | 3 | Burst length code, 000 = longest |
| cfg_start | input | 3 | Start code, 001 = convert now, 000 = none |
| cfg_on | input | 1 | 1 = converter operating, 0 = powered down |
| cmp_hi | input | 1 | Comparator: analog input >= dac_code |
| dac_code | output | RES | Trial code for the external DAC |
| mux_sel | output | log2(NCH) | Analog multiplexer select |
| res_data | output | RES | Last result, left-aligned |
| res_chan | output | log2(NCH) | Channel of the last result |
| res_done | output | 1 | One-cycle strobe with a new result |

## Verification
The sensitive coincidence is the end of a burst conversion meeting a control write that clears burst (or the on bit) on the same edge. The finishing step reads the control state from before the write, so it still chains one more conversion. The bench times a write to land exactly on a known finishing edge, using divider 0 where the edges are predictable. It then expects one further result on the wrapped-around channel, followed by silence. A second write, landing just after a finishing edge, must let only the conversion in progress complete.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int LEN_W = 3;
    localparam int ST_CODE_W = 3;
    localparam logic [ST_CODE_W-1:0] START_IDLE = 3'b000;
    localparam logic [ST_CODE_W-1:0] START_NOW  = 3'b001;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_st_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q >= div);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  cur,
    output logic [CW-1:0]  first,
    output logic [CW-1:0]  next
);
    logic [NCH-1:0] eff;
    logic           above;

    always_comb begin
        eff   = (mask == '0) ? NCH'(1) : mask;
        first = '0;
        next  = '0;
        above = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (eff[i]) begin
                first = CW'(i);
                if (i > int'(cur)) begin
                    next  = CW'(i);
                    above = 1'b1;
                end
            end
        end
        if (!above) begin
            next = first;
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int RES  = 10,
    parameter int DIVW = 8,
    localparam int CW  = $clog2(NCH),
    localparam int BW  = $clog2(RES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [NCH-1:0]       cfg_chmask,
    input  logic [DIVW-1:0]      cfg_div,
    input  logic                 cfg_burst,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [ST_CODE_W-1:0] cfg_start,
    input  logic                 cfg_on,
    input  logic                 cmp_hi,
    output logic [RES-1:0]       dac_code,
    output logic [CW-1:0]        mux_sel,
    output logic [RES-1:0]       res_data,
    output logic [CW-1:0]        res_chan,
    output logic                 res_done
);
    typedef struct packed {
        seq_st_e              st;
        logic [NCH-1:0]       mask;
        logic [DIVW-1:0]      div;
        logic                 burst;
        logic [LEN_W-1:0]     len;
        logic [ST_CODE_W-1:0] start;
        logic                 run;
        logic [CW-1:0]        chan;
        logic [RES-1:0]       sar;
        logic [BW-1:0]        pos;
        logic [BW-1:0]        left;
        logic [RES-1:0]       res;
        logic [CW-1:0]        rchan;
        logic                 done;
    } seq_regs_t;

    seq_regs_t d, q;

    logic          tick;
    logic [CW-1:0] first_ch, next_ch;
    logic [BW-1:0] burst_bits;

    adc_clk_div #(.DIVW(DIVW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.run),
        .div  (q.div),
        .tick (tick)
    );

    adc_chan_pick #(.NCH(NCH)) u_pick (
        .mask (q.mask),
        .cur  (q.chan),
        .first(first_ch),
        .next (next_ch)
    );

    assign burst_bits = BW'(RES) - BW'(q.len);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.run) begin
                    if (!q.burst && q.start == START_NOW) begin
                        d.st    = ST_CONV;
                        d.chan  = first_ch;
                        d.sar   = '0;
                        d.pos   = BW'(RES - 1);
                        d.left  = BW'(RES);
                        d.start = START_IDLE;
                    end else if (q.burst && q.start == START_IDLE) begin
                        d.st   = ST_CONV;
                        d.chan = first_ch;
                        d.sar  = '0;
                        d.pos  = BW'(RES - 1);
                        d.left = burst_bits;
                    end
                end
            end
            ST_CONV: begin
                if (!q.run) begin
                    d.st = ST_IDLE;
                end else if (tick) begin
                    if (q.left != '0) begin
                        d.sar[q.pos] = cmp_hi;
                        d.pos        = q.pos - 1'b1;
                        d.left       = q.left - 1'b1;
                    end else begin
                        d.res   = q.sar;
                        d.rchan = q.chan;
                        d.done  = 1'b1;
                        if (q.burst && q.start == START_IDLE) begin
                            d.chan = next_ch;
                            d.sar  = '0;
                            d.pos  = BW'(RES - 1);
                            d.left = burst_bits;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (cfg_we) begin
            d.mask  = cfg_chmask;
            d.div   = cfg_div;
            d.burst = cfg_burst;
            d.len   = cfg_len;
            d.start = cfg_start;
            d.run   = cfg_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mask: NCH'(1), div: '0, burst: 1'b0,
                   len: '0, start: START_IDLE, run: 1'b0, chan: '0,
                   sar: '0, pos: '0, left: '0, res: '0, rchan: '0,
                   done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dac_code = q.sar | ((q.st == ST_CONV && q.left != '0)
                               ? (RES'(1) << q.pos) : '0);
    assign mux_sel  = q.chan;
    assign res_data = q.res;
    assign res_chan = q.rchan;
    assign res_done = q.done;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           res_done,
    input logic [CHW-1:0] mux_sel,
    input logic           busy,
    input logic           run_on,
    input logic           burst_on,
    input logic [2:0]     start_code,
    input logic           trials_left
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |=> !res_done);

    // R12
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trials_left) |=> $stable(mux_sel));

    // R10
    burst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && burst_on && start_code != 3'b000) |=> !busy);

    // R4
    code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_code != 3'b000 && start_code != 3'b001) |=> !busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CHW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_done   (res_done),
    .mux_sel    (mux_sel),
    .busy       (q.st == adc_seq_pkg::ST_CONV),
    .run_on     (q.run),
    .burst_on   (q.burst),
    .start_code (q.start),
    .trials_left(q.left != '0)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_chmask = '0;
    logic [7:0] cfg_div = '0;
    logic       cfg_burst = 1'b0;
    logic [2:0] cfg_len = '0;
    logic [2:0] cfg_start = '0;
    logic       cfg_on = 1'b0;
    logic       cmp_hi;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;
    logic [9:0] res_data;
    logic [2:0] res_chan;
    logic       res_done;

    logic [9:0] ana [8];
    int cyc = 0;
    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp_hi = (ana[mux_sel] >= dac_code);

    adc_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chmask(cfg_chmask),
        .cfg_div(cfg_div), .cfg_burst(cfg_burst), .cfg_len(cfg_len),
        .cfg_start(cfg_start), .cfg_on(cfg_on), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .mux_sel(mux_sel), .res_data(res_data),
        .res_chan(res_chan), .res_done(res_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_ch(input logic [7:0] m);
        logic [7:0] e = (m == 0) ? 8'h01 : m;
        for (int i = 0; i < 8; i++) if (e[i]) return i;
        return 0;
    endfunction

    function automatic int next_ch(input logic [7:0] m, input int cur);
        logic [7:0] e = (m == 0) ? 8'h01 : m;
        for (int i = cur + 1; i < 8; i++) if (e[i]) return i;
        return low_ch(m);
    endfunction

    function automatic int popc(input logic [7:0] m);
        logic [7:0] e = (m == 0) ? 8'h01 : m;
        return $countones(e);
    endfunction

    function automatic int trunc(input int v, input int bits);
        return (v >> (10 - bits)) << (10 - bits);
    endfunction

    task automatic load_ana();
        for (int i = 0; i < 8; i++) ana[i] = 10'($urandom % 1024);
    endtask

    task automatic cfg(input logic [7:0] m, input logic [7:0] dv, input logic b,
                       input logic [2:0] ln, input logic [2:0] st, input logic on);
        @(negedge clk);
        cfg_chmask = m; cfg_div = dv; cfg_burst = b;
        cfg_len = ln; cfg_start = st; cfg_on = on; cfg_we = 1'b1;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic wait_done(input int lim, output bit got, output int stamp);
        got = 0; stamp = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (res_done) begin
                got = 1; stamp = cyc;
                break;
            end
        end
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (res_done) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic sw_conv(input logic [7:0] m, input logic [7:0] dv, input logic [2:0] ln);
        bit got; int stamp; int w; int ch; logic [9:0] held;
        load_ana();
        cfg(m, dv, 1'b0, ln, 3'b000, 1'b1);
        repeat (3) @(posedge clk);
        cfg(m, dv, 1'b0, ln, 3'b001, 1'b1);
        w = cyc;
        ch = low_ch(m);
        wait_done(12 * (dv + 1) + 8, got, stamp);
        chk(got, "R4 software done", int'(got), 1);
        chk(res_chan == 3'(ch), (m == 0) ? "R6 zero mask channel" : "R4 lowest channel",
            int'(res_chan), ch);
        chk(res_data == ana[ch], "R5 full 10-bit result", int'(res_data), int'(ana[ch]));
        if (dv == 0) chk(stamp - w == 12, "R4 latency", stamp - w, 12);
        held = res_data;
        @(posedge clk); #1;
        chk(!res_done, "R12 single-cycle done", int'(res_done), 0);
        quiet(40, "R4 start code consumed");
        chk(res_data == held, "R12 result held", int'(res_data), int'(held));
    endtask

    task automatic run_burst(input logic [7:0] m, input logic [7:0] dv, input logic [2:0] ln);
        int b = 10 - int'(ln);
        int n = 11 - int'(ln);
        int ch = low_ch(m);
        int prev = -1;
        bit got; int stamp;
        load_ana();
        cfg(m, dv, 1'b1, ln, 3'b000, 1'b1);
        for (int i = 0; i < popc(m) + 2; i++) begin
            wait_done(2 * n * (int'(dv) + 1) + 8, got, stamp);
            chk(got, "R9 burst result", int'(got), 1);
            if (!got) break;
            chk(res_chan == 3'(ch), "R9 scan order", int'(res_chan), ch);
            chk(res_data == 10'(trunc(ana[ch], b)), "R8 truncated result",
                int'(res_data), trunc(ana[ch], b));
            if (prev >= 0) chk(stamp - prev == n * (int'(dv) + 1), "R3 step spacing",
                               stamp - prev, n * (int'(dv) + 1));
            prev = stamp;
            ch = next_ch(m, ch);
        end
        cfg(m, dv, 1'b0, ln, 3'b000, 1'b0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        bit got; int stamp;
        void'($urandom(32'h0ADC_5EED));
        for (int i = 0; i < 8; i++) ana[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk(!res_done && res_data == 0 && res_chan == 0, "R1 result outputs", int'(res_data), 0);
        chk(mux_sel == 0 && dac_code == 0, "R1 drive outputs", int'(dac_code), 0);

        // R2 start while powered down
        cfg(8'h01, 8'd0, 1'b0, 3'd0, 3'b001, 1'b0);
        quiet(60, "R2 powered down");

        // R4 / R5 / R6 directed then random software conversions
        sw_conv(8'h00, 8'd0, 3'd5);
        sw_conv(8'h90, 8'd0, 3'd7);
        for (int k = 0; k < 6; k++)
            sw_conv(8'($urandom), 8'($urandom % 4), 3'($urandom));

        // R4 other start codes begin nothing
        cfg(8'h02, 8'd0, 1'b0, 3'd0, 3'b010, 1'b1);
        quiet(60, "R4 code 010 ignored");
        cfg(8'h02, 8'd0, 1'b0, 3'd0, 3'b000, 1'b0);

        // R7 edge values through a software conversion
        ana[0] = 10'h3FF; ana[1] = 10'h000;
        cfg(8'h01, 8'd0, 1'b0, 3'd0, 3'b000, 1'b1);
        cfg(8'h01, 8'd0, 1'b0, 3'd0, 3'b001, 1'b1);
        wait_done(30, got, stamp);
        chk(res_data == 10'h3FF, "R7 full scale", int'(res_data), 1023);

        // R3 / R8 / R9 bursts across every length code
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 8; c++)
                run_burst(8'($urandom), 8'($urandom % 3), 3'(c));
        run_burst(8'h00, 8'd0, 3'd0);
        run_burst(8'h81, 8'd1, 3'd7);

        // R10 burst with a nonzero start code
        cfg(8'h0F, 8'd0, 1'b1, 3'd0, 3'b001, 1'b1);
        quiet(100, "R10 burst gated");
        cfg(8'h0F, 8'd0, 1'b0, 3'd0, 3'b000, 1'b0);

        // R11 clear burst mid-conversion
        load_ana();
        cfg(8'h44, 8'd0, 1'b1, 3'd6, 3'b000, 1'b1);
        wait_done(20, got, stamp);
        chk(got && res_chan == 2, "R11 first burst result", int'(res_chan), 2);
        cfg(8'h44, 8'd0, 1'b0, 3'd6, 3'b000, 1'b1);
        wait_done(10, got, stamp);
        chk(got && res_chan == 6, "R11 in-progress completes", int'(res_chan), 6);
        chk(res_data == 10'(trunc(ana[6], 4)), "R11 completed data",
            int'(res_data), trunc(ana[6], 4));
        quiet(40, "R11 stops after clear");

        // R11 clear landing on the finishing edge
        cfg(8'h44, 8'd0, 1'b1, 3'd6, 3'b000, 1'b1);
        wait_done(20, got, stamp);
        chk(got && res_chan == 2, "R11 coincident setup", int'(res_chan), 2);
        repeat (4) @(posedge clk);
        cfg(8'h44, 8'd0, 1'b0, 3'd6, 3'b000, 1'b1);
        chk(res_done && res_chan == 6, "R11 done on write edge", int'(res_chan), 6);
        wait_done(10, got, stamp);
        chk(got && res_chan == 2, "R11 one extra conversion", int'(res_chan), 2);
        quiet(40, "R11 silent after extra");

        // R2 power down during burst
        cfg(8'hFF, 8'd1, 1'b1, 3'd0, 3'b000, 1'b1);
        wait_done(60, got, stamp);
        chk(got, "R2 burst running", int'(got), 1);
        repeat (3) @(posedge clk);
        cfg(8'hFF, 8'd1, 1'b1, 3'd0, 3'b000, 1'b0);
        quiet(100, "R2 abandoned conversion");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule